// File: doc/BRIEF.md
# Transmit Byte FIFO with Hole Skipping

This block buffers frame data between a host bus and the transmit side of an Ethernet MAC. The host stores 16-bit entries. Each write carries two byte enables, and a write that enables only one byte still takes a whole entry; the disabled byte is kept as a hole. The network side pulls bytes one at a time through a show-ahead port. Within an entry the low byte comes out before the high byte, and holes are skipped.

Two level outputs pace the two sides. The data request output compares the free entries with a watermark that is counted in write cycles. The start output tells the MAC that it may begin sending: it asserts once enough valid bytes are stored, or as soon as any stored entry carries an end-of-frame mark. Both thresholds are written through a configuration strobe. A hardware reset or a software reset brings them back to their defaults and empties the buffer.

The unload side is a three-state machine. ST_EMPTY means no entry is stored; a push moves it to ST_FIRST. ST_FIRST presents the first valid byte of the head entry. If that entry also holds a high byte still to send, a read moves the machine to ST_SECOND. Otherwise the read retires the entry, and the machine goes to ST_EMPTY if that was the last entry and no push arrives in the same cycle, or stays in ST_FIRST if not. ST_SECOND presents the high byte, and a read retires the entry with the same choice between ST_EMPTY and ST_FIRST. A software reset forces ST_EMPTY from any state.

Top module: `tx_hole_fifo`

## Requirements
- R1: After `rst_n` low, or after a cycle with `sw_rst` high, the buffer is empty (`rd_valid` 0), `tdreq` is 1, `tx_start` is 0 and `overflow` is 0. The watermark returns to 32 entries and the start threshold to 64 bytes.
- R2: A write (`wr_en` high) whose `wr_be` is nonzero takes exactly one entry, whether one or two bytes are enabled. A write with `wr_be` = 00 is ignored. `wr_be[0]` enables `wr_data[7:0]` and `wr_be[1]` enables `wr_data[15:8]`.
- R3: The buffer holds 68 entries. A nonzero-enable write made while all 68 are occupied is dropped, even if an unload happens in the same cycle, and it sets `overflow`. `overflow` then stays high until a reset.
- R4: Bytes leave in write order. Within an entry the low byte leaves before the high byte. A byte whose enable was 0 is never presented on `rd_data`.
- R5: `rd_data` is valid whenever `rd_valid` is high, and a clock edge with `rd_req` and `rd_valid` both high consumes that byte. With the buffer empty, `rd_valid` is 0 and `rd_req` has no effect.
- R6: `tdreq` is 1 exactly when the number of free entries is at least the watermark. Watermark code 0 selects 8 entries, code 1 selects 16, and codes 2 and 3 select 32. The configuration is loaded on an edge with `cfg_we` high.
- R7: Writes are still accepted after `tdreq` has fallen, as long as a free entry remains.
- R8: `tx_start` is 1 when the count of stored valid bytes is at least the start threshold. A write adds 1 or 2 to this count and each consumed byte subtracts 1. A threshold value of 1 to 64 is used as written; 0 or any value above 64 means 64.
- R9: `tx_start` is 1 while any stored entry carries an end-of-frame mark (`wr_eof` at write), whatever the byte count.
- R10: `rd_eof` is 1 together with the last valid byte of an entry written with `wr_eof`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, same effect as rst_n |
| cfg_we | input | 1 | Loads watermark code and start threshold |
| cfg_wm_code | input | 2 | Watermark code: 0=8, 1=16, 2/3=32 entries |
| cfg_start_bytes | input | 7 | Start threshold in bytes (0 or >64 means 64) |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| wr_data | input | 16 | Host write data |
| wr_eof | input | 1 | Marks the written entry as the frame end |
| rd_req | input | 1 | Network side consumes the presented byte |
| rd_valid | output | 1 | A byte is presented on rd_data |
| rd_data | output | 8 | Presented byte |
| rd_eof | output | 1 | Presented byte is the last byte of a frame |
| tdreq | output | 1 | Free entries are at or above the watermark |
| tx_start | output | 1 | Enough bytes or a frame end are stored |
| overflow | output | 1 | Sticky: a write was dropped on a full buffer |

## Verification
The bench targets entries where one byte is a hole. A design that read bytes by position instead of by enable would emit the stale byte left in the hole, or lose the real one. Runs of single-byte writes drive `tdreq` low at 37 entries, which is only 37 bytes. A design that counted bytes rather than entries would hold `tdreq` high too long, and one that stopped taking writes at that point would lose data. Filling the buffer while reading in the same cycle exposes a design that accepts a write on a full buffer. Threshold values of 0 and above 64, a one-byte frame-end entry, and a software reset taken while the buffer is full each expose wrong start, end-of-frame or default behaviour at the outputs.

// File: rtl/txh_pkg.sv
package txh_pkg;

    // One stored word: two data bytes, their valid flags and a frame-end mark.
    typedef struct packed {
        logic       eof;
        logic       hi_v;
        logic       lo_v;
        logic [7:0] hi;
        logic [7:0] lo;
    } txh_entry_t;

    // Unload position within the head entry.
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } txh_state_e;

endpackage

// File: rtl/txh_store.sv
module txh_store
    import txh_pkg::*;
#(
    parameter int DEPTH = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  txh_entry_t push_ent,
    input  logic       pop,
    output txh_entry_t head_ent
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    txh_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wr_ptr] <= push_ent;
    end

    assign head_ent = mem[rd_ptr];

    // Stored entries always hold at least one real byte.
    AST_ENTRY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_ent.lo_v || push_ent.hi_v)); // R2

endmodule

// File: rtl/txh_unload.sv
module txh_unload
    import txh_pkg::*;
#(
    parameter int ENT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             rd_req,
    input  txh_entry_t       head_ent,
    input  logic [ENT_W-1:0] ent_cnt,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_eof,
    output logic             byte_pop,
    output logic             ent_pop
);

    txh_state_e state_q;
    txh_state_e state_d;
    logic       sel_hi;
    logic       last_in_ent;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_EMPTY;
        else if (clr) state_q <= ST_EMPTY;
        else          state_q <= state_d;
    end

    // Outputs: pick the first valid byte, or the high byte on the second pass.
    always_comb begin
        sel_hi      = (state_q == ST_SECOND) || !head_ent.lo_v;
        last_in_ent = (state_q == ST_SECOND) || !(head_ent.lo_v && head_ent.hi_v);
        rd_valid    = (state_q != ST_EMPTY);
        rd_data     = sel_hi ? head_ent.hi : head_ent.lo;
        rd_eof      = rd_valid && last_in_ent && head_ent.eof;
        byte_pop    = rd_valid && rd_req;
        ent_pop     = byte_pop && last_in_ent;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_FIRST;
            end
            ST_FIRST, ST_SECOND: begin
                if (byte_pop) begin
                    if (!last_in_ent)                          state_d = ST_SECOND;
                    else if (ent_cnt == ENT_W'(1) && !push)    state_d = ST_EMPTY;
                    else                                       state_d = ST_FIRST;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (ent_cnt == '0)); // R5
    AST_SECOND_HAS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |-> (head_ent.lo_v && head_ent.hi_v)); // R4
    AST_NO_HOLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (sel_hi ? head_ent.hi_v : head_ent.lo_v)); // R4
    AST_EMPTY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !push && !clr) |=> (state_q == ST_EMPTY)); // R5

endmodule

// File: rtl/txh_level.sv
module txh_level #(
    parameter int DEPTH     = 68,
    parameter int START_MAX = 64,
    parameter int WM_LO     = 8,
    parameter int WM_MID    = 16,
    parameter int WM_HI     = 32,
    parameter logic [1:0] WM_DEF = 2'd2,
    localparam int ENT_W    = $clog2(DEPTH + 1),
    localparam int VB_W     = $clog2(2 * DEPTH + 1),
    localparam int START_W  = $clog2(START_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_wm,
    input  logic [START_W-1:0] cfg_start,
    input  logic               wr_try,
    input  logic               push,
    input  logic               push_two,
    input  logic               push_eof,
    input  logic               ent_pop,
    input  logic               ent_pop_eof,
    input  logic               byte_pop,
    output logic [ENT_W-1:0]   ent_cnt,
    output logic               full,
    output logic               tdreq,
    output logic               tx_start,
    output logic               ovf
);

    logic [1:0]         wm_q;
    logic [START_W-1:0] start_q;
    logic [VB_W-1:0]    vb_cnt;
    logic [ENT_W-1:0]   eof_cnt;
    logic [ENT_W-1:0]   free_ent;
    logic [START_W-1:0] start_eff;
    logic [1:0]         add_bytes;

    function automatic logic [ENT_W-1:0] wm_entries(input logic [1:0] code);
        case (code)
            2'd0:    return ENT_W'(WM_LO);
            2'd1:    return ENT_W'(WM_MID);
            default: return ENT_W'(WM_HI);
        endcase
    endfunction

    always_comb begin
        full      = (ent_cnt == ENT_W'(DEPTH));
        free_ent  = ENT_W'(DEPTH) - ent_cnt;
        tdreq     = (free_ent >= wm_entries(wm_q));
        start_eff = (start_q == '0 || start_q > START_W'(START_MAX))
                    ? START_W'(START_MAX) : start_q;
        tx_start  = (vb_cnt >= VB_W'(start_eff)) || (eof_cnt != '0);
        add_bytes = push ? (push_two ? 2'd2 : 2'd1) : 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wm_q    <= WM_DEF;
            start_q <= START_W'(START_MAX);
            ent_cnt <= '0;
            vb_cnt  <= '0;
            eof_cnt <= '0;
            ovf     <= 1'b0;
        end else if (clr) begin
            wm_q    <= WM_DEF;
            start_q <= START_W'(START_MAX);
            ent_cnt <= '0;
            vb_cnt  <= '0;
            eof_cnt <= '0;
            ovf     <= 1'b0;
        end else begin
            if (cfg_we) begin
                wm_q    <= cfg_wm;
                start_q <= cfg_start;
            end
            ent_cnt <= ent_cnt + ENT_W'(push) - ENT_W'(ent_pop);
            vb_cnt  <= vb_cnt + VB_W'(add_bytes) - VB_W'(byte_pop);
            eof_cnt <= eof_cnt + ENT_W'(push && push_eof) - ENT_W'(ent_pop && ent_pop_eof);
            if (wr_try && full) ovf <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cnt <= ENT_W'(DEPTH)); // R3
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_try && !ent_pop && !clr) |=> (ent_cnt == $past(ent_cnt))); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R3
    AST_BYTES_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (VB_W'(ent_cnt) <= vb_cnt) && (vb_cnt <= VB_W'({ent_cnt, 1'b0}))); // R8
    AST_EOF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        eof_cnt <= ent_cnt); // R9

endmodule

// File: rtl/tx_hole_fifo.sv
module tx_hole_fifo
    import txh_pkg::*;
#(
    parameter int DEPTH     = 68,
    parameter int START_MAX = 64,
    localparam int ENT_W    = $clog2(DEPTH + 1),
    localparam int START_W  = $clog2(START_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_wm_code,
    input  logic [START_W-1:0] cfg_start_bytes,
    input  logic               wr_en,
    input  logic [1:0]         wr_be,
    input  logic [15:0]        wr_data,
    input  logic               wr_eof,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               rd_eof,
    output logic               tdreq,
    output logic               tx_start,
    output logic               overflow
);

    txh_entry_t       push_ent;
    txh_entry_t       head_ent;
    logic             wr_try;
    logic             push;
    logic             full;
    logic             byte_pop;
    logic             ent_pop;
    logic [ENT_W-1:0] ent_cnt;

    always_comb begin
        wr_try        = wr_en && (wr_be != 2'b00);
        push          = wr_try && !full;
        push_ent.eof  = wr_eof;
        push_ent.hi_v = wr_be[1];
        push_ent.lo_v = wr_be[0];
        push_ent.hi   = wr_data[15:8];
        push_ent.lo   = wr_data[7:0];
    end

    txh_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (ent_pop),
        .head_ent (head_ent)
    );

    txh_unload #(.ENT_W(ENT_W)) unload_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_rst),
        .push     (push),
        .rd_req   (rd_req),
        .head_ent (head_ent),
        .ent_cnt  (ent_cnt),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_eof   (rd_eof),
        .byte_pop (byte_pop),
        .ent_pop  (ent_pop)
    );

    txh_level #(.DEPTH(DEPTH), .START_MAX(START_MAX)) level_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (sw_rst),
        .cfg_we      (cfg_we),
        .cfg_wm      (cfg_wm_code),
        .cfg_start   (cfg_start_bytes),
        .wr_try      (wr_try),
        .push        (push),
        .push_two    (wr_be == 2'b11),
        .push_eof    (wr_eof),
        .ent_pop     (ent_pop),
        .ent_pop_eof (head_ent.eof),
        .byte_pop    (byte_pop),
        .ent_cnt     (ent_cnt),
        .full        (full),
        .tdreq       (tdreq),
        .tx_start    (tx_start),
        .ovf         (overflow)
    );

    AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ent_pop && !sw_rst) |=> !rd_valid || $stable(ent_cnt) || ent_cnt < $past(ent_cnt)); // R3

endmodule

// File: tb/tx_hole_fifo_tb_top.sv
`timescale 1ns/1ps
module tx_hole_fifo_tb_top;

    localparam int DEPTH = 68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wm_code = 2'd0;
    logic [6:0]  cfg_start_bytes = 7'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        wr_eof = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_eof;
    logic        tdreq;
    logic        tx_start;
    logic        overflow;

    always #2.5 clk = ~clk;

    tx_hole_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we),
        .cfg_wm_code(cfg_wm_code), .cfg_start_bytes(cfg_start_bytes),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .wr_eof(wr_eof),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
        .tdreq(tdreq), .tx_start(tx_start), .overflow(overflow)
    );

    // Reference model: byte queue (bit 8 = frame end on this byte) plus per-entry counts.
    logic [8:0] m_bytes[$];
    int         m_left[$];
    bit         m_eof[$];
    int         m_wm = 32;
    int         m_start = 64;
    bit         m_ovf = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic int exp_wm(input logic [1:0] code);
        return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
    endfunction

    function automatic int exp_start(input logic [6:0] v);
        return (v == 0 || v > 64) ? 64 : int'(v);
    endfunction

    function automatic bit any_eof();
        foreach (m_eof[i]) if (m_eof[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_bytes.delete();
        m_left.delete();
        m_eof.delete();
        m_wm = 32;
        m_start = 64;
        m_ovf = 1'b0;
    endtask

    task automatic compare();
        bit ev;
        bit es;
        ev = (m_bytes.size() > 0);
        chk(rd_valid == ev, "R5", "rd_valid", int'(rd_valid), int'(ev));
        if (ev) begin
            chk(rd_data == m_bytes[0][7:0], "R4", "rd_data", int'(rd_data), int'(m_bytes[0][7:0]));
        end
        chk(rd_eof == (ev && m_bytes[0][8]), "R10", "rd_eof", int'(rd_eof), int'(ev && m_bytes[0][8]));
        chk(tdreq == ((DEPTH - m_left.size()) >= m_wm), "R6 (entry use R2 R7)", "tdreq",
            int'(tdreq), int'((DEPTH - m_left.size()) >= m_wm));
        es = (m_bytes.size() >= m_start) || any_eof();
        chk(tx_start == es, any_eof() ? "R9" : "R8", "tx_start", int'(tx_start), int'(es));
        chk(overflow == m_ovf, "R3", "overflow", int'(overflow), int'(m_ovf));
    endtask

    // Called at a falling edge: compare, drive, predict the next rising edge.
    task automatic step(input bit we, input bit [1:0] be, input bit [15:0] d, input bit eof,
                        input bit rr, input bit cw = 1'b0, input bit [1:0] wmc = 2'd0,
                        input bit [6:0] st = 7'd0, input bit sw = 1'b0);
        bit full_now;
        compare();
        wr_en = we; wr_be = be; wr_data = d; wr_eof = eof; rd_req = rr;
        cfg_we = cw; cfg_wm_code = wmc; cfg_start_bytes = st; sw_rst = sw;
        if (sw) begin
            model_clear();
        end else begin
            full_now = (m_left.size() == DEPTH);
            if (rr && m_bytes.size() > 0) begin
                void'(m_bytes.pop_front());
                m_left[0] = m_left[0] - 1;
                if (m_left[0] == 0) begin
                    void'(m_left.pop_front());
                    void'(m_eof.pop_front());
                end
            end
            if (we && be != 2'b00) begin
                if (full_now) m_ovf = 1'b1;
                else begin
                    if (be[0]) m_bytes.push_back({1'b0, d[7:0]});
                    if (be[1]) m_bytes.push_back({1'b0, d[15:8]});
                    if (eof) m_bytes[m_bytes.size()-1][8] = 1'b1;
                    m_left.push_back(be == 2'b11 ? 2 : 1);
                    m_eof.push_back(eof);
                end
            end
            if (cw) begin
                m_wm = exp_wm(wmc);
                m_start = exp_start(st);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic check_defaults(input string tag);
        chk(rd_valid == 1'b0, tag, "rd_valid after reset", int'(rd_valid), 0);
        chk(tdreq == 1'b1, tag, "tdreq after reset", int'(tdreq), 1);
        chk(tx_start == 1'b0, tag, "tx_start after reset", int'(tx_start), 0);
        chk(overflow == 1'b0, tag, "overflow after reset", int'(overflow), 0);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7141);
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("R1");
        idle();

        // R2 R7 R3: single-byte writes (holes) past the watermark, then into full.
        for (int i = 0; i < DEPTH + 4; i++) begin
            step(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10, 16'(16'h1100 + i * 3), 1'b0, 1'b0);
        end
        step(1'b1, 2'b11, 16'hBEEF, 1'b0, 1'b1);  // full, read same cycle: still dropped (R3)
        step(1'b1, 2'b00, 16'hDEAD, 1'b0, 1'b0);  // zero enables ignored (R2)
        // R4: drain every byte, no hole may appear.
        for (int i = 0; i < DEPTH + 6; i++) step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1);

        // R1: software reset drops overflow and config.
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, 7'd0, 1'b1);
        check_defaults("R1");

        // R6 R8: watermark 8, threshold 10 with word writes.
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd10);
        for (int i = 0; i < 64; i++) step(1'b1, 2'b11, 16'(i * 257 + 5), 1'b0, 1'b0);
        for (int i = 0; i < 130; i++) step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1);

        // R8: threshold 0 and 100 both act as 64.
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b1, 2'd1, 7'd0);
        for (int i = 0; i < 34; i++) step(1'b1, 2'b11, 16'(i + 77), 1'b0, 1'b0);
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1, 1'b1, 2'd3, 7'd100);
        idle();
        for (int i = 0; i < 70; i++) step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1);

        // R9 R10: one-byte frame end in the high lane.
        step(1'b1, 2'b10, 16'hA55A, 1'b1, 1'b0);
        idle();
        step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1);
        idle();

        // Constrained random segments.
        for (int seg = 0; seg < 12; seg++) begin
            int pw;
            int pr;
            pw = 20 + int'($urandom_range(0, 75));
            pr = 20 + int'($urandom_range(0, 75));
            for (int i = 0; i < 250; i++) begin
                bit cw;
                bit sw;
                cw = ($urandom_range(0, 99) == 0);
                sw = (seg == 7 && i == 200);
                step(($urandom_range(0, 99) < pw), 2'($urandom_range(0, 3)), 16'($urandom),
                     ($urandom_range(0, 15) == 0), ($urandom_range(0, 99) < pr),
                     cw, 2'($urandom_range(0, 3)), 7'($urandom_range(0, 90)), sw);
            end
        end
        for (int i = 0; i < 160; i++) step(1'b0, 2'b00, 16'h0, 1'b0, 1'b1);
        compare();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (R1..) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule